// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is a free-running up-counter for a memory-mapped timekeeping peripheral. A slow clock enters as a one-cycle tick enable in the bus clock domain. A programmable prescaler divides that tick stream, and every completed division period advances a running count by one. With the usual slow-clock rate, each count is one second. Software cannot load the count. It can only restart it from zero, and it adds its own base time elsewhere.

An alarm compare register raises an alarm event on the increment that brings the count to the stored value. Every increment also raises an increment event. Both events are latched in a status word that is cleared when it is read. The interrupt line is raised when a latched event has its enable bit set.

Software reaches the block through a simple register bus with four 32-bit words. Read data is combinational in the cycle of the access, and a status read clears the flags at the clock edge that ends the access.

Top module: `secs_timer`

## Requirements
- R1: After reset the control word (byte address 0x0) reads 0x0000_8000, the count (0x8) reads 0, the alarm word (0x4) reads all ones over the count width, the status word (0xC) reads 0, and `irq` is low.
- R2: With a prescale value P, the count advances by one on every P-th slow tick (P of 0 or 1 advances it on every tick). It wraps from its maximum to zero.
- R3: In the control word, bits [15:0] hold the prescale value, bit 16 enables the alarm interrupt and bit 17 enables the increment interrupt. All three read back as written.
- R4: Writing the control word with bit 18 set clears the count and the prescale divider in the same cycle. The next increment comes a full P ticks later, and bit 18 always reads as 0.
- R5: Writes to the count word and to the status word have no effect.
- R6: Status bit 0 (alarm) is set by the increment that makes the count equal to the alarm word. It stays set until the status word is read.
- R7: Status bit 1 (increment) is set by every increment of the count.
- R8: A read of the status word returns the flags and clears both of them. An event occurring in the same cycle as that read stays latched.
- R9: `irq` is high exactly when (status bit 0 and enable bit 16) or (status bit 1 and enable bit 17).
- R10: Two consecutive reads of the count with no increment between them return identical values.
- R11: The alarm word reads back the value last written, truncated to the count width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with an 8-bit count and keeps the 16-bit prescale field. The narrow count brings the wrap from 255 to 0, and alarm matches that occur after the wrap, within a few hundred ticks. The bench sweeps prescale values 0 through 5 tick by tick against the quotient it computes itself. It then sweeps alarm values 1 through 12 and checks the status word after every increment. It also covers a restart in the middle of a period, a status read that falls in the same cycle as an event, and each combination of enable bit and latched flag on `irq`.

// File: rtl/secs_timer_pkg.sv
package secs_timer_pkg;
   // word index taken from bus_addr[3:2]
   typedef enum logic [1:0] {
      W_CTRL  = 2'd0,
      W_ALARM = 2'd1,
      W_COUNT = 2'd2,
      W_STAT  = 2'd3
   } word_e;

   localparam int BIT_ALM_EN  = 16;
   localparam int BIT_INC_EN  = 17;
   localparam int BIT_RESTART = 18;
   localparam int BUS_W       = 32;
   localparam int PRE_FIELD_W = 16;
endpackage

// File: rtl/secs_timer_prescaler.sv
module secs_timer_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre_val,
   output logic             inc_pulse
);
   localparam int EXT_W = PRE_W + 1;

   logic [PRE_W-1:0] div_q;
   logic [EXT_W-1:0] div_next;
   logic             period_done;

   assign div_next    = {1'b0, div_q} + EXT_W'(1);
   assign period_done = div_next >= {1'b0, pre_val};
   assign inc_pulse   = slow_tick & ~restart & period_done;

   always_ff @(posedge clk) begin
      if (!rst_n)
         div_q <= '0;
      else if (restart)
         div_q <= '0;
      else if (slow_tick)
         div_q <= period_done ? '0 : div_next[PRE_W-1:0];
   end

   assert_restart_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> div_q == '0);
   assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_tick && !restart && !inc_pulse) |=> div_q == $past(div_q) + PRE_W'(1));
   assert_div_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!slow_tick && !restart) |=> $stable(div_q));
endmodule

// File: rtl/secs_timer_counter.sv
module secs_timer_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             restart,
   input  logic [CNT_W-1:0] alarm_val,
   output logic [CNT_W-1:0] count,
   output logic             alarm_hit
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_inc;

   assign count_inc = count_q + CNT_W'(1);
   assign alarm_hit = inc & (count_inc == alarm_val);
   assign count     = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else if (restart)
         count_q <= '0;
      else if (inc)
         count_q <= count_inc;
   end

   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> count == '0);
   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !restart) |=> count == $past(count) + CNT_W'(1));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !restart) |=> $stable(count));
   assert_alarm_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> count == $past(alarm_val));
endmodule

// File: rtl/secs_timer_status.sv
module secs_timer_status (
   input  logic clk,
   input  logic rst_n,
   input  logic alm_evt,
   input  logic inc_evt,
   input  logic rd_clr,
   output logic alm_st,
   output logic inc_st
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_st <= 1'b0;
         inc_st <= 1'b0;
      end else begin
         alm_st <= (alm_st & ~rd_clr) | alm_evt;
         inc_st <= (inc_st & ~rd_clr) | inc_evt;
      end
   end

   assert_clear_alm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !alm_evt) |=> !alm_st);
   assert_keep_alm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alm_evt |=> alm_st);
   assert_sticky_alm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_st && !rd_clr) |=> alm_st);
   assert_keep_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inc_evt |=> inc_st);
endmodule

// File: rtl/secs_timer.sv
module secs_timer
   import secs_timer_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int PRE_W     = 16,
   parameter int PRE_RESET = 32768
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slow_tick,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   localparam int CNT_PAD = BUS_W - CNT_W;
   localparam int PRE_PAD = PRE_FIELD_W - PRE_W;

   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt_w
      $error("secs_timer: CNT_W must lie in 2..32");
   end
   if (PRE_W < 1 || PRE_W > PRE_FIELD_W) begin : g_bad_pre_w
      $error("secs_timer: PRE_W must lie in 1..16");
   end
   if (PRE_RESET < 0 || PRE_RESET >= (1 << PRE_W)) begin : g_bad_pre_rst
      $error("secs_timer: PRE_RESET does not fit in PRE_W");
   end

   word_e            word;
   logic             wr_ctrl, wr_alarm, rd_stat, restart;
   logic [PRE_W-1:0] pre_q;
   logic             alm_en_q, inc_en_q;
   logic [CNT_W-1:0] alarm_q, count;
   logic             inc_pulse, alarm_hit, alm_st, inc_st;
   logic [31:0]      count_ext, alarm_ext;
   logic [15:0]      pre_ext;
   logic             unused_bus_bits;

   assign word     = word_e'(bus_addr[3:2]);
   assign wr_ctrl  = bus_sel & bus_wr & (word == W_CTRL);
   assign wr_alarm = bus_sel & bus_wr & (word == W_ALARM);
   assign rd_stat  = bus_sel & ~bus_wr & (word == W_STAT);
   assign restart  = wr_ctrl & bus_wdata[BIT_RESTART];
   assign unused_bus_bits = ^{bus_addr[1:0], bus_wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q    <= PRE_W'(PRE_RESET);
         alm_en_q <= 1'b0;
         inc_en_q <= 1'b0;
         alarm_q  <= '1;
      end else begin
         if (wr_ctrl) begin
            pre_q    <= bus_wdata[PRE_W-1:0];
            alm_en_q <= bus_wdata[BIT_ALM_EN];
            inc_en_q <= bus_wdata[BIT_INC_EN];
         end
         if (wr_alarm)
            alarm_q <= bus_wdata[CNT_W-1:0];
      end
   end

   secs_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .restart(restart),
      .pre_val(pre_q), .inc_pulse(inc_pulse)
   );

   secs_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_pulse), .restart(restart),
      .alarm_val(alarm_q), .count(count), .alarm_hit(alarm_hit)
   );

   secs_timer_status u_stat (
      .clk(clk), .rst_n(rst_n), .alm_evt(alarm_hit), .inc_evt(inc_pulse),
      .rd_clr(rd_stat), .alm_st(alm_st), .inc_st(inc_st)
   );

   // zero-extension to the bus width, chosen by parameter
   if (CNT_PAD == 0) begin : g_cnt_full
      assign count_ext = count;
      assign alarm_ext = alarm_q;
   end else begin : g_cnt_pad
      assign count_ext = {{CNT_PAD{1'b0}}, count};
      assign alarm_ext = {{CNT_PAD{1'b0}}, alarm_q};
   end
   if (PRE_PAD == 0) begin : g_pre_full
      assign pre_ext = pre_q;
   end else begin : g_pre_pad
      assign pre_ext = {{PRE_PAD{1'b0}}, pre_q};
   end

   always_comb begin
      bus_rdata = '0;
      unique case (word)
         W_CTRL:  bus_rdata = {13'd0, 1'b0, inc_en_q, alm_en_q, pre_ext};
         W_ALARM: bus_rdata = alarm_ext;
         W_COUNT: bus_rdata = count_ext;
         W_STAT:  bus_rdata = {30'd0, inc_st, alm_st};
         default: bus_rdata = '0;
      endcase
   end

   assign irq = (alm_st & alm_en_q) | (inc_st & inc_en_q);

   assert_value_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && word == W_COUNT && !inc_pulse) |=> $stable(count));
   assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !inc_pulse && !wr_ctrl) |=> !irq);
   assert_restart_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (bus_sel && !bus_wr && word == W_CTRL) |-> !bus_rdata[BIT_RESTART]);
   assert_alarm_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_alarm |=> $stable(alarm_q));
endmodule

// File: tb/secs_timer_tb.sv
module secs_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int CMAX       = 1 << CNT_W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int vectors = 0;
   int miscompares = 0;

   secs_timer #(.CNT_W(CNT_W), .PRE_W(16), .PRE_RESET(32768)) u_dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
   endtask

   function automatic logic [31:0] ctrl(input int pre, input bit aen, input bit ien, input bit rst);
      return {13'd0, rst, ien, aen, 16'(pre)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] d, d2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(4'h0, d); check("R1 ctrl", d, 32'h0000_8000);
      bus_read(4'h4, d); check("R1 alarm", d, 32'h0000_00FF);
      bus_read(4'h8, d); check("R1 count", d, 32'h0);
      bus_read(4'hC, d); check("R1 status", d, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);

      // R3 control readback, R4 restart bit reads zero
      bus_write(4'h0, 32'h0003_1234);
      bus_read(4'h0, d); check("R3 ctrl readback", d, 32'h0003_1234);
      bus_write(4'h0, ctrl(7, 0, 0, 1));
      bus_read(4'h0, d); check("R4 restart reads 0", d, 32'h0000_0007);

      // R11 alarm readback truncated to count width
      bus_write(4'h4, 32'h0000_ABCD);
      bus_read(4'h4, d); check("R11 alarm readback", d, 32'h0000_00CD);

      // R2 prescale sweep 0..5
      for (int p = 0; p <= 5; p++) begin
         int div;
         div = (p < 1) ? 1 : p;
         bus_write(4'h0, ctrl(p, 0, 0, 1));
         for (int k = 1; k <= 3 * div + 2; k++) begin
            tick();
            bus_read(4'h8, d);
            check($sformatf("R2 prescale %0d tick %0d", p, k), d, 32'(k / div));
         end
      end

      // R4 restart mid-period
      bus_write(4'h0, ctrl(4, 0, 0, 1));
      tick(); tick();
      bus_write(4'h0, ctrl(4, 0, 0, 1));
      bus_read(4'h8, d); check("R4 count cleared", d, 32'h0);
      tick(); tick(); tick();
      bus_read(4'h8, d); check("R4 full period pending", d, 32'h0);
      tick();
      bus_read(4'h8, d); check("R4 full period done", d, 32'h1);

      // R6 R7 alarm sweep with status read after each increment
      for (int a = 1; a <= 12; a++) begin
         bus_write(4'h0, ctrl(1, 0, 0, 1));
         bus_write(4'h4, 32'(a));
         bus_read(4'hC, d);
         for (int k = 1; k <= a + 1; k++) begin
            tick();
            bus_read(4'hC, d);
            check($sformatf("R6 R7 alarm %0d tick %0d", a, k), d,
                  {30'd0, 1'b1, (k == a)});
         end
      end

      // R2 wrap and R6 sticky alarm across it
      bus_write(4'h0, ctrl(1, 0, 0, 1));
      bus_write(4'h4, 32'h80);
      bus_read(4'hC, d);
      for (int k = 0; k < CMAX + 2; k++) tick();
      bus_read(4'h8, d); check("R2 wrap", d, 32'((CMAX + 2) % CMAX));
      bus_read(4'hC, d); check("R6 sticky alarm", d, 32'h3);
      bus_read(4'hC, d); check("R8 cleared after read", d, 32'h0);

      // R5 writes to count and status ignored
      bus_write(4'h8, 32'h55);
      bus_read(4'h8, d); check("R5 count write ignored", d, 32'h2);
      bus_write(4'hC, 32'h3);
      bus_read(4'hC, d); check("R5 status write ignored", d, 32'h0);

      // R10 back-to-back count reads
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h8;
      #1 d = bus_rdata;
      @(negedge clk);
      #1 d2 = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
      check("R10 coherent reads", d2, d);

      // R8 event in the same cycle as a status read is kept
      bus_write(4'h4, 32'h3);
      @(negedge clk);
      slow_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'hC;
      #1 d = bus_rdata;
      @(negedge clk);
      slow_tick = 1'b0; bus_sel = 1'b0;
      check("R8 read returns old flags", d, 32'h0);
      bus_read(4'hC, d); check("R8 event kept", d, 32'h3);

      // R9 interrupt gating
      bus_write(4'h0, ctrl(1, 1, 0, 1));
      bus_write(4'h4, 32'h2);
      bus_read(4'hC, d);
      tick();
      check("R9 inc flag without enable", {31'd0, irq}, 32'h0);
      tick();
      check("R9 alarm flag with enable", {31'd0, irq}, 32'h1);
      bus_write(4'h0, ctrl(1, 0, 0, 0));
      check("R9 both enables off", {31'd0, irq}, 32'h0);
      bus_write(4'h0, ctrl(1, 0, 1, 0));
      check("R9 inc enable on", {31'd0, irq}, 32'h1);
      bus_read(4'hC, d);
      check("R9 cleared by status read", {31'd0, irq}, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule